// File: doc/BRIEF.md
# Single-Wire Bus Request/Grant Arbiter

This block handles local bus handover from the processor to alternate bus masters. Each master has one active-low, open-drain wire. A handover uses three low pulses on that wire, each one clock long. The master pulses to request the bus. The processor pulses back to grant it. The master pulses again when it is done. The block samples every wire and decides when a grant may go out relative to the running bus cycle. It drives the grant pulse, and it reports when the processor must float its bus and which master owns it. After the release pulse the processor takes the bus back, and one dead clock follows before any further grant.

A grant can be issued as soon as the bus is idle. When a memory or I/O cycle is running, a grant is allowed only in that cycle's last state (T4), and only if all of these hold:
- the request was seen by T2;
- the cycle is not the lower half of a split word;
- the cycle is not the first interrupt acknowledge.

A lock input holds off every grant. The lowest-numbered channel wins whenever several channels are eligible. A request that arrives while another master holds the bus is remembered and served later.

Top module: `rqgt_arbiter`

## Requirements
- R1: A low level on `rg_in[i]` at a clock edge, while the processor is not granting or lending the bus to channel i, is latched as a request. With the bus idle and no lock, the processor grants at the next edge: `rg_oe[i]` is high for exactly one clock.
- R2: `rg_out` is always 0. At most one bit of `rg_oe` is ever high, and only during a grant clock.
- R3: `bus_float` rises at the edge that ends the grant clock, and `hold_ch` names the granted channel. `bus_float` stays high until the edge at which the owning channel's wire is sampled low, and drops at that edge.
- R4: After `bus_float` falls, at least one clock passes with no grant.
- R5: When several channels are eligible at the same decision edge, the lowest-numbered channel is granted. The others stay pending and are served after the next handover.
- R6: While `cyc_active` is 1, a grant clock starts only after an edge at which `tstate` is T4. The `tstate` encoding is T1=0, T2=1, T3 or wait=2, T4=3.
- R7: A request first latched at an edge where `tstate` is T3 or wait is not granted at that cycle's T4. It is granted at the T4 of the following cycle.
- R8: No grant is issued at a T4 edge where `low_half` or `inta_first` is 1. The request stays pending for a later cycle.
- R9: No grant is issued at an edge where `lock_act` is 1. The request stays pending and is granted once lock is sampled low.
- R10: A request on one channel made while another channel holds the bus is latched. It is granted two edges after the release edge, which leaves one dead clock in between.
- R11: Reset (`rst` high) clears all pending requests and holds `rg_oe` and `bus_float` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| rg_in | input | NCH | Sampled level of each request/grant wire (low = pulse) |
| cyc_active | input | 1 | A memory or I/O bus cycle is in progress |
| tstate | input | TSW | Current bus state: 0=T1, 1=T2, 2=T3/wait, 3=T4 |
| low_half | input | 1 | Current cycle is the lower-byte half of a split word |
| inta_first | input | 1 | Current cycle is the first interrupt acknowledge |
| lock_act | input | 1 | Bus lock active; grants held off |
| rg_oe | output | NCH | Pull wire i low (grant pulse) when bit i is 1 |
| rg_out | output | NCH | Value driven when enabled (always 0) |
| bus_float | output | 1 | Processor must float its local bus |
| hold_ch | output | CW | Channel that owns or is being granted the bus |

## Verification
If the sequencer held the wrong state, the error would reach the ports within one or two clocks. A grant pulse would last two clocks, `bus_float` would fail to follow a grant, or a grant would land in the dead clock. If a pending or late flag were corrupted, the result would be a grant at the wrong T4 or no grant at all. That shows at the latest by the next eligible cycle end. If the priority pick were wrong, `rg_oe` would show the wrong bit on the first grant after a simultaneous request.

// File: rtl/rqgt_arbiter.sv
`timescale 1ns/1ps
module rqgt_arbiter #(
  parameter int NCH = 2,
  parameter int TSW = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] rg_in,
  input  logic           cyc_active,
  input  logic [TSW-1:0] tstate,
  input  logic           low_half,
  input  logic           inta_first,
  input  logic           lock_act,
  output logic [NCH-1:0] rg_oe,
  output logic [NCH-1:0] rg_out,
  output logic           bus_float,
  output logic [CW-1:0]  hold_ch
);
  localparam logic [TSW-1:0] TS_T3 = TSW'(2);
  localparam logic [TSW-1:0] TS_T4 = TSW'(3);

  typedef enum logic [1:0] {S_IDLE, S_GRANT, S_HOLD, S_DEAD} st_t;
  st_t st;
  logic [NCH-1:0] pend, late, elig, seen, own_mask, pick_mask;
  logic [CW-1:0]  own, pick;
  logic           found, cyc_end, side_ok, go;

  always_comb begin
    own_mask = '0;
    own_mask[own] = 1'b1;
  end

  assign seen    = ~rg_in & (((st == S_GRANT) || (st == S_HOLD)) ? ~own_mask : {NCH{1'b1}});
  assign cyc_end = cyc_active && (tstate == TS_T4);
  assign side_ok = !lock_act && (!cyc_active || (cyc_end && !low_half && !inta_first));
  assign elig    = cyc_active ? (pend & ~late) : pend;
  assign found   = |elig;
  assign go      = (st == S_IDLE) && found && side_ok;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) pick = CW'(i);
    pick_mask = '0;
    pick_mask[pick] = go;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st   <= S_IDLE;
      own  <= '0;
      pend <= '0;
      late <= '0;
    end else begin
      pend <= (pend | seen) & ~pick_mask;
      if (cyc_end)
        late <= '0;
      else
        late <= (late | (seen & {NCH{cyc_active && (tstate == TS_T3)}})) & ~pick_mask;
      case (st)
        S_IDLE:  if (go) begin st <= S_GRANT; own <= pick; end
        S_GRANT: st <= S_HOLD;
        S_HOLD:  if (!rg_in[own]) st <= S_DEAD;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rg_oe     = (st == S_GRANT) ? own_mask : '0;
  assign rg_out    = '0;
  assign bus_float = (st == S_HOLD);
  assign hold_ch   = own;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(rg_oe));
  // R1
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (rst) (|rg_oe) |=> (rg_oe == '0));
  // R3
  float_after_gnt_chk: assert property (@(posedge clk) disable iff (rst) (|rg_oe) |=> bus_float);
  // R4
  dead_cycle_chk: assert property (@(posedge clk) disable iff (rst) $fell(bus_float) |=> (rg_oe == '0));
  // R9
  lock_block_chk: assert property (@(posedge clk) disable iff (rst) (|rg_oe) |-> !$past(lock_act));
  // R6
  t4_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((|rg_oe) && $past(cyc_active)) |-> ($past(tstate) == TS_T4));
endmodule

// File: tb/rqgt_arbiter_tb.sv
`timescale 1ns/1ps
module rqgt_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rg_in = 2'b11;
  logic cyc_active = 1'b0;
  logic [1:0] tstate = 2'd0;
  logic low_half = 1'b0, inta_first = 1'b0, lock_act = 1'b0;
  logic [1:0] rg_oe, rg_out;
  logic bus_float;
  logic hold_ch;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rqgt_arbiter #(.NCH(2), .TSW(2)) dut_i (
    .clk(clk), .rst(rst), .rg_in(rg_in), .cyc_active(cyc_active), .tstate(tstate),
    .low_half(low_half), .inta_first(inta_first), .lock_act(lock_act),
    .rg_oe(rg_oe), .rg_out(rg_out), .bus_float(bus_float), .hold_ch(hold_ch));

  // row: {rg_in[2], cyc, tstate[2], low, inta, lock, exp_oe[2], exp_float}
  localparam int NV = 63;
  localparam logic [10:0] VEC [NV] = '{
    11'b11_0_00_000_00_0, // 0  R11 idle after reset
    11'b10_0_00_000_00_0, // 1  R1 ch0 request
    11'b11_0_00_000_01_0, // 2  R1 grant ch0
    11'b11_0_00_000_00_1, // 3  R3 float
    11'b11_0_00_000_00_1, // 4  R3 held
    11'b10_0_00_000_00_0, // 5  R3 release
    11'b11_0_00_000_00_0, // 6  R4 dead
    11'b01_0_00_000_00_0, // 7  R1 ch1 request
    11'b11_0_00_000_10_0, // 8  R1 grant ch1
    11'b10_0_00_000_00_1, // 9  R10 ch0 asks during ch1 hold
    11'b11_0_00_000_00_1, // 10 R10
    11'b01_0_00_000_00_0, // 11 R3 ch1 release
    11'b11_0_00_000_00_0, // 12 R4 dead
    11'b11_0_00_000_01_0, // 13 R10 ch0 served
    11'b11_0_00_000_00_1, // 14
    11'b10_0_00_000_00_0, // 15
    11'b11_0_00_000_00_0, // 16
    11'b00_0_00_000_00_0, // 17 R5 both request
    11'b11_0_00_000_01_0, // 18 R5 ch0 wins
    11'b11_0_00_000_00_1, // 19
    11'b10_0_00_000_00_0, // 20
    11'b11_0_00_000_00_0, // 21 R4
    11'b11_0_00_000_10_0, // 22 R5 ch1 after
    11'b11_0_00_000_00_1, // 23
    11'b01_0_00_000_00_0, // 24
    11'b11_0_00_000_00_0, // 25
    11'b10_0_00_001_00_0, // 26 R9 request under lock
    11'b11_0_00_001_00_0, // 27 R9
    11'b11_0_00_001_00_0, // 28 R9
    11'b11_0_00_000_01_0, // 29 R9 lock gone
    11'b11_0_00_000_00_1, // 30
    11'b10_0_00_000_00_0, // 31
    11'b11_0_00_000_00_0, // 32
    11'b10_1_00_000_00_0, // 33 R6 request at T1
    11'b11_1_01_000_00_0, // 34 R6 T2
    11'b11_1_10_000_00_0, // 35 R6 T3
    11'b11_1_11_000_01_0, // 36 R6 grant at T4
    11'b11_0_00_000_00_1, // 37
    11'b10_0_00_000_00_0, // 38
    11'b11_0_00_000_00_0, // 39
    11'b10_1_10_000_00_0, // 40 R7 late request at T3
    11'b11_1_11_000_00_0, // 41 R7 not this T4
    11'b11_1_00_000_00_0, // 42
    11'b11_1_01_000_00_0, // 43
    11'b11_1_10_000_00_0, // 44
    11'b11_1_11_000_01_0, // 45 R7 next T4
    11'b11_0_00_000_00_1, // 46
    11'b10_0_00_000_00_0, // 47
    11'b11_0_00_000_00_0, // 48
    11'b01_1_01_000_00_0, // 49 R8 ch1 request at T2
    11'b11_1_10_000_00_0, // 50
    11'b11_1_11_100_00_0, // 51 R8 lower half blocks
    11'b11_1_00_000_00_0, // 52
    11'b11_1_01_000_00_0, // 53
    11'b11_1_10_000_00_0, // 54
    11'b11_1_11_010_00_0, // 55 R8 first acknowledge blocks
    11'b11_1_00_000_00_0, // 56
    11'b11_1_01_000_00_0, // 57
    11'b11_1_10_000_00_0, // 58
    11'b11_1_11_000_10_0, // 59 R8 granted
    11'b11_0_00_000_00_1, // 60
    11'b01_0_00_000_00_0, // 61
    11'b11_0_00_000_00_0  // 62
  };
  localparam int TAG [NV] = '{
    11,1,1,3,3,3,4,1,1,10,10,3,4,10,3,3,4,5,5,3,3,4,5,3,3,4,9,9,9,9,3,3,4,
    6,6,6,6,3,3,4,7,7,7,7,7,7,3,3,4,8,8,8,8,8,8,8,8,8,8,8,3,3,4};

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic check(input int tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    // R11 outputs held in reset
    check(11, {1'b0, rg_oe, bus_float}, 4'b0000);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {rg_in, cyc_active, tstate, low_half, inta_first, lock_act} = VEC[i][10:3];
      tick();
      check(TAG[i], {1'b0, rg_oe, bus_float}, {1'b0, VEC[i][2:0]});
    end
    // directed: ch1 hold, hold_ch, constant drive value (R2, R3)
    rg_in = 2'b01; tick();
    rg_in = 2'b11; tick();
    check(2, {rg_oe, rg_out}, 4'b1000);
    tick();
    for (int k = 0; k < 5; k++) begin
      check(3, {1'b0, hold_ch, bus_float, rg_oe == 2'b00}, 4'b0111);
      tick();
    end
    // R11 reset during hold, also with a fresh ch0 request pending
    rg_in = 2'b10; tick();
    rg_in = 2'b11;
    rst = 1'b1; tick();
    check(11, {1'b0, rg_oe, bus_float}, 4'b0000);
    rst = 1'b0; tick(); tick();
    check(11, {1'b0, rg_oe, bus_float}, 4'b0000);
    tick();
    check(11, {1'b0, rg_oe, bus_float}, 4'b0000);
    finish_run();
  end
endmodule